// File: doc/BRIEF.md
# Transceiver Standby Wake-Up Filter

This block is the digital mode controller that sits between a host protocol controller and the analog front end of a CAN bus transceiver. A host standby pin chooses between two modes. With the pin low, the transmitter is enabled and the receive output simply mirrors the bus: dominant shows as low, recessive as high. With the pin high, the transmitter is held off, so the bus is never driven. The receive output then stays high and acts as a wake-up request line instead of a data line.

While in standby, the block times how long the bus has been dominant without a break. A single recessive sample sets that time back to zero. Once the dominant level has lasted for the full filter window, the receive output goes low and stays low, even after the bus goes recessive again. The host sees this as a wake-up request. The block never returns to normal operation on its own. Only the host can end standby, by pulling the pin low, and doing so also clears the latched request. Both inputs cross into the clock domain through synchronizer chains. Every output comes straight from a register.

Top module: `can_wake_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock edge after it rises, the block enters standby: `mode_stby`=1, `tx_en`=0, `rxd`=1. Any wake-up request that was held is cleared.
- R2: `stby_pin`=0 selects normal mode (`mode_stby`=0, `tx_en`=1), and `stby_pin`=1 selects standby mode (`mode_stby`=1). A change on the pin reaches the outputs SYNC_STAGES+1 clock edges after it is first sampled (3 edges by default).
- R3: In normal mode, `rxd` is the inverse of `bus_dom`, where `bus_dom`=1 means dominant, so `rxd`=0 means dominant. The latency is the same SYNC_STAGES+1 edges.
- R4: In standby, `tx_en` is 0 on every cycle.
- R5: In standby, `rxd` stays 1 as long as the bus has never been dominant for WAKE_CYCLES consecutive synchronized samples. A dominant run of WAKE_CYCLES-1 samples leaves `rxd` at 1.
- R6: In standby, a single recessive sample restarts the dominant-duration count from zero. Two runs of WAKE_CYCLES-1 dominant samples separated by one recessive sample do not cause a wake-up.
- R7: In standby, WAKE_CYCLES consecutive dominant samples drive `rxd` to 0 as a wake-up request. The default value of WAKE_CYCLES is 750000, which is 3 ms at 250 MHz.
- R8: Once the wake-up request is raised, `rxd` stays 0 while `stby_pin` stays high, whatever the bus does.
- R9: Only a low `stby_pin` ends standby. Ending standby clears the wake-up request, so the next entry into standby starts with `rxd`=1. If the pin's low level reaches the logic in the same cycle that the dominant run would qualify, normal mode wins: no request is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_pin | input | 1 | Host mode select: 1 = standby, 0 = normal (asynchronous) |
| bus_dom | input | 1 | Bus state from the receivers: 1 = dominant (asynchronous) |
| rxd | output | 1 | Receive data to host, 0 = dominant or wake-up request |
| tx_en | output | 1 | Transmitter enable, 1 = driver may drive the bus |
| mode_stby | output | 1 | Current mode, 1 = standby |

## Verification
Two functions can collide in one cycle. One is the wake qualifier reaching its final dominant sample. The other is the host's standby release arriving out of its synchronizer. The bench provokes this by holding the bus dominant and pulling `stby_pin` low exactly WAKE_CYCLES-1 input cycles after the dominant level starts, so that both synchronized signals change in the same cycle. It then judges the result at the ports. `rxd` must follow the bus in normal mode. After the host re-enters standby with a recessive bus, `rxd` must read 1, which proves no request was latched. The run-length boundary (WAKE_CYCLES-1 against WAKE_CYCLES samples) and the restart on a single recessive sample are checked on their own.

// File: rtl/wkf_pkg.sv
package wkf_pkg;
  typedef enum logic {
    MODE_NORMAL = 1'b0,
    MODE_STBY   = 1'b1
  } xm_mode_e;

  localparam logic RXD_DOM = 1'b0;
  localparam logic RXD_REC = 1'b1;
endpackage

// File: rtl/wkf_sync.sv
module wkf_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RST_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[i] <= RST_VAL;
          else     chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/wkf_dur_cnt.sv
module wkf_dur_cnt #(
  parameter int LIMIT = 750000
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic dom,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (rst || !en || !dom) begin
      run_q <= '0;
    end else if (run_q != LAST) begin
      run_q <= run_q + 1'b1;
    end
  end

  assign hit = en && dom && (run_q == LAST);
endmodule

// File: rtl/wkf_mode_out.sv
module wkf_mode_out
  import wkf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic stb_s,
  input  logic dom_s,
  input  logic hit,
  output logic rxd,
  output logic tx_en,
  output logic mode_stby
);
  xm_mode_e mode_q;
  logic     wake_q;
  logic     wake_nx;

  assign wake_nx = wake_q || hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_STBY;
      tx_en  <= 1'b0;
      wake_q <= 1'b0;
      rxd    <= RXD_REC;
    end else if (stb_s) begin
      mode_q <= MODE_STBY;
      tx_en  <= 1'b0;
      wake_q <= wake_nx;
      rxd    <= wake_nx ? RXD_DOM : RXD_REC;
    end else begin
      mode_q <= MODE_NORMAL;
      tx_en  <= 1'b1;
      wake_q <= 1'b0;
      rxd    <= dom_s ? RXD_DOM : RXD_REC;
    end
  end

  assign mode_stby = (mode_q == MODE_STBY);
endmodule

// File: rtl/can_wake_ctrl.sv
module can_wake_ctrl #(
  parameter int WAKE_CYCLES = 750000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic stby_pin,
  input  logic bus_dom,
  output logic rxd,
  output logic tx_en,
  output logic mode_stby
);
  logic stb_s;
  logic dom_s;
  logic hit;

  wkf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_stb (
    .clk(clk), .rst(rst), .d(stby_pin), .q(stb_s)
  );

  wkf_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dom (
    .clk(clk), .rst(rst), .d(bus_dom), .q(dom_s)
  );

  wkf_dur_cnt #(.LIMIT(WAKE_CYCLES)) u_dur (
    .clk(clk), .rst(rst), .en(stb_s), .dom(dom_s), .hit(hit)
  );

  wkf_mode_out u_out (
    .clk(clk), .rst(rst), .stb_s(stb_s), .dom_s(dom_s), .hit(hit),
    .rxd(rxd), .tx_en(tx_en), .mode_stby(mode_stby)
  );
endmodule

// File: rtl/can_wake_ctrl_chk.sv
module can_wake_ctrl_chk #(
  parameter int SYNC_STAGES = 2
) (
  input logic clk,
  input logic rst,
  input logic stby_pin,
  input logic bus_dom,
  input logic rxd,
  input logic tx_en,
  input logic mode_stby
);
  localparam int LAT = SYNC_STAGES + 1;
  localparam int AW  = $clog2(LAT + 1);

  logic [LAT-1:0] pin_pipe;
  logic [LAT-1:0] dom_pipe;
  logic [AW-1:0]  age;

  always_ff @(posedge clk) begin
    pin_pipe <= {pin_pipe[LAT-2:0], stby_pin};
    dom_pipe <= {dom_pipe[LAT-2:0], bus_dom};
    if (rst)                 age <= '0;
    else if (age != AW'(LAT)) age <= age + 1'b1;
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mode_stby && !tx_en && rxd));

  p_mode_follows_pin_r2: assert property (@(posedge clk) disable iff (rst)
    (age == AW'(LAT)) |-> (mode_stby == pin_pipe[LAT-1]));

  p_txen_in_normal_r2: assert property (@(posedge clk) disable iff (rst)
    !mode_stby |-> tx_en);

  p_rxd_mirrors_bus_r3: assert property (@(posedge clk) disable iff (rst)
    ((age == AW'(LAT)) && !mode_stby) |-> (rxd == !dom_pipe[LAT-1]));

  p_no_drive_in_stby_r4: assert property (@(posedge clk) disable iff (rst)
    mode_stby |-> !tx_en);

  p_wake_persists_r8: assert property (@(posedge clk) disable iff (rst)
    (mode_stby && !rxd) |=> (!mode_stby || !rxd));
endmodule

bind can_wake_ctrl can_wake_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk(clk), .rst(rst), .stby_pin(stby_pin), .bus_dom(bus_dom),
  .rxd(rxd), .tx_en(tx_en), .mode_stby(mode_stby)
);

// File: tb/can_wake_ctrl_bench.sv
`timescale 1ns/1ps
module can_wake_ctrl_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic stby_pin = 1'b1;
  logic bus_dom = 1'b0;
  logic rxd, tx_en, mode_stby;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  can_wake_ctrl #(.WAKE_CYCLES(W), .SYNC_STAGES(2)) u_can_wake_ctrl (
    .clk(clk), .rst(rst), .stby_pin(stby_pin), .bus_dom(bus_dom),
    .rxd(rxd), .tx_en(tx_en), .mode_stby(mode_stby)
  );

  // {stby_pin, bus_dom, exp rxd, exp tx_en, exp mode_stby}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00_1_1_0,
    5'b01_0_1_0,
    5'b00_1_1_0,
    5'b10_1_0_1,
    5'b11_1_0_1,
    5'b01_0_1_0,
    5'b11_1_0_1,
    5'b00_1_1_0
  };

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic dom_run(input int n);
    bus_dom = 1'b1;
    tick(n);
    bus_dom = 1'b0;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        total++;
        bad++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    tick(5);
    chk("R1", "mode_stby in reset", mode_stby, 1'b1);
    chk("R1", "tx_en in reset", tx_en, 1'b0);
    chk("R1", "rxd in reset", rxd, 1'b1);
    rst = 1'b0;
    tick(1);
    chk("R1", "mode_stby after release", mode_stby, 1'b1);

    // table walk, R2 R3 R4 R5
    for (int k = 0; k < 8; k++) begin
      stby_pin = VEC[k][4];
      bus_dom  = VEC[k][3];
      tick(4);
      chk("R3", $sformatf("vec%0d rxd", k), rxd, VEC[k][2]);
      chk("R2", $sformatf("vec%0d tx_en", k), tx_en, VEC[k][1]);
      chk("R2", $sformatf("vec%0d mode_stby", k), mode_stby, VEC[k][0]);
    end

    // R3 latency in normal mode: 3 edges
    stby_pin = 1'b0; bus_dom = 1'b0; tick(5);
    bus_dom = 1'b1;
    tick(2);
    chk("R3", "rxd before latency", rxd, 1'b1);
    tick(1);
    chk("R3", "rxd at latency", rxd, 1'b0);
    bus_dom = 1'b0;
    tick(2);
    chk("R2", "mode before latency", mode_stby, 1'b0);
    stby_pin = 1'b1;
    tick(2);
    chk("R2", "mode still normal", mode_stby, 1'b0);
    tick(1);
    chk("R2", "mode at latency", mode_stby, 1'b1);
    tick(6);

    // R5: W-1 dominant samples, no wake
    dom_run(W - 1);
    tick(8);
    chk("R5", "rxd after short run", rxd, 1'b1);

    // R6: two short runs split by one recessive sample
    bus_dom = 1'b1; tick(W - 1);
    bus_dom = 1'b0; tick(1);
    bus_dom = 1'b1; tick(W - 1);
    bus_dom = 1'b0; tick(8);
    chk("R6", "rxd after split runs", rxd, 1'b1);

    // R7: exactly W dominant samples wakes
    dom_run(W);
    tick(8);
    chk("R7", "rxd after full run", rxd, 1'b0);
    chk("R4", "tx_en during wake", tx_en, 1'b0);

    // R8: latched with recessive bus
    tick(20);
    chk("R8", "rxd held low", rxd, 1'b0);
    chk("R8", "still standby", mode_stby, 1'b1);

    // R9: host exit clears request
    stby_pin = 1'b0; tick(4);
    chk("R9", "mode after exit", mode_stby, 1'b0);
    chk("R9", "rxd recessive after exit", rxd, 1'b1);
    stby_pin = 1'b1; tick(4);
    chk("R9", "rxd after re-entry", rxd, 1'b1);

    // R9: exit collides with qualifying sample
    tick(4);
    bus_dom = 1'b1;
    tick(W - 1);
    stby_pin = 1'b0;
    tick(6);
    chk("R9", "collision mode", mode_stby, 1'b0);
    chk("R9", "collision rxd follows bus", rxd, 1'b0);
    bus_dom = 1'b0; tick(4);
    chk("R9", "collision rxd recessive", rxd, 1'b1);
    stby_pin = 1'b1; tick(6);
    chk("R9", "no wake kept after collision", rxd, 1'b1);

    // R1: reset mid-operation after a wake
    dom_run(W); tick(6);
    chk("R7", "wake before reset", rxd, 1'b0);
    rst = 1'b1; tick(1);
    chk("R1", "rxd after reset", rxd, 1'b1);
    chk("R1", "mode after reset", mode_stby, 1'b1);
    rst = 1'b0; tick(6);
    chk("R1", "wake cleared by reset", rxd, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    done = 1;
    $finish;
  end
endmodule